// File: doc/BRIEF.md
# Indirect Interrupt Register Window

This block is a memory-mapped slave that gives software access to the internal registers of an interrupt routing controller. Only two bus locations are exposed. One is a select location that holds a register index. The other is a 32-bit data window that reads or writes whichever internal register the index names. Behind the window sit four kinds of register:

- an identification register;
- a read-only version word that reports the number of routing entries;
- an arbitration alias of the identification register;
- a table of 64-bit routing entries, each reached as a low half and a high half.

The routing table is stored inside this block and is exported as a flat vector to the interrupt service logic. Every accepted write to a table half raises a one-cycle pulse, so that the service logic evaluates the pending requests again. The bus side is a single-cycle request interface. A write takes effect at the clock edge on which the request is sampled. Read data is a combinational function of the request and of the stored state.

Top module: `irw_top`

## Requirements
- R1: After reset the select register, the identification field and every table entry are zero, and `svc_pulse` is low.
- R2: Only `bus_addr[7:0]` is decoded, and the upper address bits have no effect. Offset 0x00 is the select location and offset 0x10 is the data window. A read at any other offset returns 0, and a write there changes nothing.
- R3: A write to the select location stores `bus_wdata[7:0]`, whatever the access size. A read of the select location returns that value in bits 7:0, with bits 31:8 zero.
- R4: A window access whose `bus_size` is not 4 (bytes) is ignored. A read returns 0. A write changes no register and raises no pulse.
- R5: A window write with index 0 stores `bus_wdata[27:24]` as the identification field. Window reads with index 0 and with index 2 both return that field in bits 27:24, with all other bits zero.
- R6: A window read with index 1 returns `VER_CODE` in bits 7:0 and NPINS-1 in bits 23:16, with all other bits zero. Window writes with index 1 or index 2 are discarded.
- R7: Index 0x10+2n reaches bits 31:0 of table entry n, and index 0x11+2n reaches bits 63:32 of that entry, for n from 0 to NPINS-1. A read returns the stored half.
- R8: A write to one half of an entry replaces that half only; the other half keeps its value. The change appears on `tbl_flat[64n +: 64]` in the cycle after the write edge.
- R9: `svc_pulse` is high for exactly the one cycle that follows the edge of an accepted table-half write. It stays low after all other accesses.
- R10: Indices 3 to 0x0F, and indices from 0x10+2*NPINS upward, read as 0 through the window, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is requested |
| tbl_flat | output | 64*NPINS | Routing table, entry n at bits 64n+63:64n |
| svc_pulse | output | 1 | One-cycle request to the service logic to evaluate again |

## Verification
The bench builds the block with NPINS = 4, so the whole index space of the select register can be swept. Every index from 0 to 0x1F is written and read back, and the bench then compares every result against an arithmetic model of the ID, version and table. At this size the upper table edge (index 0x18) and the gap below the table base both fall inside the sweep, and so does the entry-count field of the version word (value 3). Wrong access sizes, unknown offsets and upper address bits are then applied to state that is already known, so any unwanted change can be seen.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] TBL_BASE = 8'h10;
  localparam int         ID_LSB   = 24;
  localparam int         CNT_LSB  = 16;

  // entry number reached by a table index
  function automatic logic [7:0] tbl_entry(input logic [7:0] sel);
    logic [7:0] d;
    d = sel - TBL_BASE;
    return {1'b0, d[7:1]};
  endfunction

  // index falls inside the table of npins entries
  function automatic logic tbl_in_range(input logic [7:0] sel, input int npins);
    return (sel >= TBL_BASE) && (int'(sel) < int'(TBL_BASE) + 2 * npins);
  endfunction

  // version word: code in the low byte, last entry number in the count field
  function automatic logic [31:0] ver_word(input logic [7:0] code, input int npins);
    logic [7:0] cnt;
    cnt = 8'(npins - 1);
    return (32'(cnt) << CNT_LSB) | 32'(code);
  endfunction
endpackage

// File: rtl/irw_decode.sv
module irw_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic              sel_acc,
  output logic              win_acc,
  output logic              win_ok
);
  import irw_pkg::*;

  logic [7:0] off;
  assign off = addr[7:0];

  generate
    if (ADDR_W > 8) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr[ADDR_W-1:8];
    end
  endgenerate

  assign sel_acc = (off == OFF_SEL);
  assign win_acc = (off == OFF_WIN);
  assign win_ok  = win_acc && (size == 3'd4);
endmodule

// File: rtl/irw_select.sv
module irw_select (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  logic [7:0] wdata_lo,
  output logic [7:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= wdata_lo;
  end
endmodule

// File: rtl/irw_ctrl_regs.sv
module irw_ctrl_regs #(
  parameter int         NPINS    = 24,
  parameter int         ID_W     = 4,
  parameter logic [7:0] VER_CODE = 8'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_win,
  input  logic [7:0]      sel,
  input  logic [ID_W-1:0] wdata_id,
  output logic [ID_W-1:0] id_q,
  output logic            ctrl_hit,
  output logic [31:0]     ctrl_rd
);
  import irw_pkg::*;

  logic wr_id;
  assign wr_id = wr_win && (sel == IDX_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (wr_id) id_q <= wdata_id;
  end

  assign ctrl_hit = (sel == IDX_ID) || (sel == IDX_VER) || (sel == IDX_ARB);

  always_comb begin
    unique case (sel)
      IDX_ID, IDX_ARB: ctrl_rd = 32'(id_q) << ID_LSB;
      IDX_VER:         ctrl_rd = ver_word(VER_CODE, NPINS);
      default:         ctrl_rd = '0;
    endcase
  end
endmodule

// File: rtl/irw_table.sv
module irw_table #(
  parameter int NPINS = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_win,
  input  logic [7:0]         sel,
  input  logic [31:0]        wdata,
  output logic [64*NPINS-1:0] tbl_flat,
  output logic               tbl_hit,
  output logic [31:0]        tbl_rd
);
  import irw_pkg::*;

  logic [7:0] ent;
  assign ent     = tbl_entry(sel);
  assign tbl_hit = tbl_in_range(sel, NPINS);

  for (genvar e = 0; e < NPINS; e++) begin : g_ent
    logic [63:0] ent_q;
    logic        sel_me, lo_we, hi_we;
    assign sel_me = tbl_hit && (int'(ent) == e);
    assign lo_we  = wr_win && sel_me && !sel[0];
    assign hi_we  = wr_win && sel_me &&  sel[0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else begin
        if (lo_we) ent_q[31:0]  <= wdata;
        if (hi_we) ent_q[63:32] <= wdata;
      end
    end
    assign tbl_flat[64*e +: 64] = ent_q;
  end

  always_comb begin
    tbl_rd = '0;
    for (int e = 0; e < NPINS; e++) begin
      if (tbl_hit && int'(ent) == e)
        tbl_rd = sel[0] ? tbl_flat[64*e+32 +: 32] : tbl_flat[64*e +: 32];
    end
  end
endmodule

// File: rtl/irw_top.sv
module irw_top #(
  parameter int         NPINS    = 24,
  parameter int         ADDR_W   = 12,
  parameter int         ID_W     = 4,
  parameter logic [7:0] VER_CODE = 8'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [2:0]          bus_size,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [64*NPINS-1:0] tbl_flat,
  output logic                svc_pulse
);
  import irw_pkg::*;

  logic            sel_acc, win_acc, win_ok;
  logic            wr_sel, wr_win;
  logic [7:0]      sel_q;
  logic [ID_W-1:0] id_q;
  logic            ctrl_hit, tbl_hit;
  logic [31:0]     ctrl_rd, tbl_rd;

  irw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .size(bus_size),
    .sel_acc(sel_acc), .win_acc(win_acc), .win_ok(win_ok)
  );

  assign wr_sel = bus_req && bus_we && sel_acc;
  assign wr_win = bus_req && bus_we && win_ok;

  irw_select u_sel (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel),
    .wdata_lo(bus_wdata[7:0]), .sel_q(sel_q)
  );

  irw_ctrl_regs #(.NPINS(NPINS), .ID_W(ID_W), .VER_CODE(VER_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_win(wr_win), .sel(sel_q),
    .wdata_id(bus_wdata[ID_LSB +: ID_W]), .id_q(id_q),
    .ctrl_hit(ctrl_hit), .ctrl_rd(ctrl_rd)
  );

  irw_table #(.NPINS(NPINS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_win(wr_win), .sel(sel_q),
    .wdata(bus_wdata), .tbl_flat(tbl_flat),
    .tbl_hit(tbl_hit), .tbl_rd(tbl_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_pulse <= 1'b0;
    else        svc_pulse <= wr_win && tbl_hit;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we) begin
      if (sel_acc)     bus_rdata = {24'b0, sel_q};
      else if (win_ok) bus_rdata = ctrl_hit ? ctrl_rd : tbl_rd;
    end
  end
endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 12,
  parameter int ID_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_req,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [64*NPINS-1:0] tbl_flat,
  input logic                svc_pulse,
  input logic                sel_acc,
  input logic                win_acc,
  input logic                win_ok,
  input logic                tbl_hit,
  input logic [7:0]          sel_q,
  input logic [ID_W-1:0]     id_q
);
  logic known_off;
  assign known_off = (bus_addr[7:0] == 8'h00) || (bus_addr[7:0] == 8'h10);

  AST_UNKNOWN_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && !known_off |-> bus_rdata == 32'd0); // R2
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we && sel_acc) |=> $stable(sel_q)); // R3
  AST_BADSIZE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && win_acc && !win_ok |=> $stable(tbl_flat) && $stable(id_q) && !svc_pulse); // R4
  AST_BADSIZE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && win_acc && !win_ok |-> bus_rdata == 32'd0); // R4
  AST_ARB_ALIASES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && win_ok && sel_q == 8'h02 |-> bus_rdata == (32'(id_q) << 24)); // R5
  AST_ID_RO_ALIASES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && win_ok && (sel_q == 8'h01 || sel_q == 8'h02) |=> $stable(id_q)); // R6
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && win_ok && tbl_hit |=> svc_pulse); // R9
  AST_PULSE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pulse |-> $past(bus_req && bus_we && win_ok && tbl_hit)); // R9
  AST_OUT_RANGE_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && win_ok && !tbl_hit |=> $stable(tbl_flat)); // R10
endmodule

bind irw_top irw_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tbl_flat(tbl_flat),
  .svc_pulse(svc_pulse), .sel_acc(sel_acc), .win_acc(win_acc),
  .win_ok(win_ok), .tbl_hit(tbl_hit), .sel_q(sel_q), .id_q(id_q)
);

// File: tb/irw_top_tb.sv
module irw_top_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         NP         = 4;
  localparam int         AW         = 12;
  localparam logic [7:0] VER        = 8'h20;

  logic              clk = 0, rst_n = 0;
  logic              bus_req = 0, bus_we = 0;
  logic [AW-1:0]     bus_addr = '0;
  logic [2:0]        bus_size = 3'd4;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic [64*NP-1:0]  tbl_flat;
  logic              svc_pulse;

  int ntests = 0, nfail = 0;
  bit done = 0;

  logic [63:0] m_tbl [NP];
  logic [3:0]  m_id;

  irw_top #(.NPINS(NP), .ADDR_W(AW), .ID_W(4), .VER_CODE(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tbl_flat(tbl_flat), .svc_pulse(svc_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write: returns the pulse seen in the cycle after the write edge
  task automatic wr(input logic [AW-1:0] a, input logic [2:0] sz, input logic [31:0] d, output logic pulse);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    pulse = svc_pulse;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
    bus_req = 0;
  endtask

  function automatic logic [31:0] exp_win(input int idx);
    if (idx == 0 || idx == 2) return {4'b0, m_id, 24'b0};
    if (idx == 1) return {8'b0, 8'(NP - 1), 8'b0, VER};
    if (idx >= 16 && idx < 16 + 2*NP)
      return (idx % 2 == 1) ? m_tbl[(idx-16)/2][63:32] : m_tbl[(idx-16)/2][31:0];
    return 32'd0;
  endfunction

  function automatic string tag_of(input int idx);
    if (idx == 0 || idx == 2) return "R5";
    if (idx == 1) return "R6";
    if (idx >= 16 && idx < 16 + 2*NP) return "R7";
    return "R10";
  endfunction

  task automatic check_table(input string req);
    for (int e = 0; e < NP; e++)
      check(tbl_flat[64*e +: 64] === m_tbl[e], req, tbl_flat[64*e +: 64], m_tbl[e]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      ntests++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic p;
    logic [31:0] d;
    for (int e = 0; e < NP; e++) m_tbl[e] = '0;
    m_id = '0;
    repeat (3) @(negedge clk);
    #1 check(svc_pulse === 1'b0, "R1 pulse", 64'(svc_pulse), 0);
    check_table("R1 table");
    rst_n = 1;
    rd(12'h000, 3'd4, d); check(d === 32'd0, "R1 sel", 64'(d), 0);
    rd(12'h010, 3'd4, d); check(d === 32'd0, "R1 id", 64'(d), 0);

    // write sweep over every index
    for (int idx = 0; idx < 32; idx++) begin
      logic [31:0] val;
      logic        exp_p;
      val = 32'hA5000000 ^ (32'(idx) * 32'h01030507);
      wr(12'h000, 3'd1, 32'(idx), p);
      rd(12'h000, 3'd4, d); check(d === 32'(idx), "R3 select readback", 64'(d), 64'(idx));
      wr(12'h010, 3'd4, val, p);
      exp_p = 0;
      if (idx == 0) m_id = val[27:24];
      else if (idx >= 16 && idx < 16 + 2*NP) begin
        exp_p = 1;
        if (idx % 2 == 1) m_tbl[(idx-16)/2][63:32] = val;
        else              m_tbl[(idx-16)/2][31:0]  = val;
      end
      check(p === exp_p, "R9 pulse", 64'(p), 64'(exp_p));
      @(negedge clk);
      check(svc_pulse === 1'b0, "R9 single cycle", 64'(svc_pulse), 0);
      check_table("R8 export");
    end

    // read sweep
    for (int idx = 0; idx < 32; idx++) begin
      wr(12'h000, 3'd4, 32'(idx), p);
      rd(12'h010, 3'd4, d);
      check(d === exp_win(idx), tag_of(idx), 64'(d), 64'(exp_win(idx)));
    end

    // half replacement keeps the other half
    wr(12'h000, 3'd4, 32'h13, p);
    wr(12'h010, 3'd4, 32'hDEADBEEF, p);
    m_tbl[1][63:32] = 32'hDEADBEEF;
    check_table("R8 hi half only");
    wr(12'h000, 3'd4, 32'h12, p);
    wr(12'h010, 3'd4, 32'h0BADF00D, p);
    m_tbl[1][31:0] = 32'h0BADF00D;
    check_table("R8 lo half only");

    // wrong access sizes on the window
    for (int sz = 0; sz < 8; sz++) begin
      if (sz == 4) continue;
      wr(12'h010, 3'(sz), 32'h12345678, p);
      check(p === 1'b0, "R4 no pulse", 64'(p), 0);
      check_table("R4 table kept");
      rd(12'h010, 3'(sz), d);
      check(d === 32'd0, "R4 read zero", 64'(d), 0);
    end
    wr(12'h000, 3'd4, 32'h0, p);
    wr(12'h010, 3'd2, 32'h0F000000, p);
    rd(12'h010, 3'd4, d); check(d === exp_win(0), "R4 id kept", 64'(d), 64'(exp_win(0)));

    // ID aliases and read-only registers
    wr(12'h010, 3'd4, 32'hF7FFFFFF, p); m_id = 4'h7;
    rd(12'h010, 3'd4, d); check(d === 32'h07000000, "R5 id field", 64'(d), 64'h07000000);
    wr(12'h000, 3'd4, 32'h2, p);
    wr(12'h010, 3'd4, 32'h0C000000, p);
    rd(12'h010, 3'd4, d); check(d === 32'h07000000, "R6 arb write dropped", 64'(d), 64'h07000000);
    wr(12'h000, 3'd4, 32'h1, p);
    wr(12'h010, 3'd4, 32'hFFFFFFFF, p);
    rd(12'h010, 3'd4, d); check(d === 32'h00030020, "R6 version", 64'(d), 64'h00030020);

    // address decode: upper bits alias, unknown offsets
    wr(12'h000, 3'd4, 32'h16, p);
    rd(12'hF10, 3'd4, d); check(d === m_tbl[3][31:0], "R2 upper bits ignored", 64'(d), 64'(m_tbl[3][31:0]));
    rd(12'h300, 3'd4, d); check(d === 32'h16, "R2 select alias", 64'(d), 64'h16);
    for (int off = 1; off < 256; off += 7) begin
      if (off == 16) continue;
      wr(12'(off), 3'd4, 32'h11, p);
      check(p === 1'b0, "R2 no pulse", 64'(p), 0);
      rd(12'(off), 3'd4, d); check(d === 32'd0, "R2 unknown read", 64'(d), 0);
    end
    rd(12'h000, 3'd4, d); check(d === 32'h16, "R2 select kept", 64'(d), 64'h16);
    check_table("R2 table kept");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule